// File: doc/BRIEF.md
# Split Two-Way Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations for a processor core. It keeps two independent buffers, one serving instruction fetches and one serving data accesses, each organised as a set-associative array with two ways per set. Pages are 4 KiB: the low 12 address bits pass straight through, and the bits above them are translated. A flag on each way records which way of the set was used most recently, and that flag decides where the next fill lands.

A lookup is combinational against the stored arrays. It presents a virtual address, a select that picks the instruction or data buffer, and a probe-only qualifier. It returns a hit flag and the physical address. The surrounding logic fills a buffer after it has walked the page table itself. It can also invalidate one page by address, and an invalidation acts on both buffers at once. Fills and invalidations take effect at the next clock edge.

Top module: `xlat_pair_tlb`

## Requirements
- R1: After reset every entry of both buffers is invalid and all most-recently-used flags are clear, so every lookup misses.
- R2: A lookup that misses drives lk_hit=0 and lk_pa=0 and changes no stored state.
- R3: A fill writes way 0 of the set when way 0's most-recently-used flag is clear, otherwise way 1. It stores the tag fl_va[31:12] and the page base fl_rpn<<12, marks that way valid, sets its flag and clears the other way's flag. A lookup of that page one cycle later hits.
- R4: The set index is va[17:12] and the tag is va[31:12]. On a hit lk_pa = {stored real page number, lk_va[11:0]}.
- R5: lk_ifetch=1 selects the instruction buffer and lk_ifetch=0 selects the data buffer, both for lookups and, through fl_ifetch, for fills. An entry filled into one buffer never hits in the other.
- R6: A hit with lk_req=1 and lk_probe=0 sets the hitting way's most-recently-used flag and clears the other way's flag, so the next fill to that set replaces the other way.
- R7: A hit with lk_probe=1 leaves the replacement state unchanged.
- R8: An invalidation marks invalid every way in set inv_va[17:12] of both buffers whose tag equals inv_va[31:12]. Other ways keep their contents.
- R9: A fill and an invalidation in the same cycle apply the invalidation after the fill, so a page that is filled and invalidated together ends up invalid.
- R10: When both ways of a set hold a valid entry with the lookup's tag, way 0 supplies the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup is a real access; a hit may update the replacement state |
| lk_va | input | 32 | Lookup virtual address |
| lk_ifetch | input | 1 | 1 = instruction buffer, 0 = data buffer |
| lk_probe | input | 1 | Probe only: never touches the replacement state |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address, 0 on a miss |
| fl_en | input | 1 | Fill strobe |
| fl_va | input | 32 | Fill virtual address |
| fl_rpn | input | 20 | Fill real page number |
| fl_ifetch | input | 1 | Fill target: 1 = instruction, 0 = data |
| inv_en | input | 1 | Invalidate strobe |
| inv_va | input | 32 | Virtual address of the page to invalidate in both buffers |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 12-bit page offset and 64 sets per buffer. With 64 sets, addresses that differ only in bit 18 and above fall in the same set. This lets three pages compete for two ways and exposes the replacement order, the effect of probe-only lookups and the way-0 priority on duplicate tags. Set 63 and the all-ones address reach the top of the index and tag fields, and matching fill and invalidate addresses on the two buffers show that one invalidation clears both.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int unsigned NWAYS = 2;

   typedef enum logic {
      WAY0 = 1'b0,
      WAY1 = 1'b1
   } way_e;

   // replacement choice: the way whose recent-use flag is clear
   function automatic way_e pick_victim(input logic [NWAYS-1:0] recent);
      return recent[0] ? WAY1 : WAY0;
   endfunction

   // hit priority: the lower way wins when both compare equal
   function automatic way_e pick_hit(input logic [NWAYS-1:0] match);
      return match[0] ? WAY0 : WAY1;
   endfunction

   // one-hot recent-use pattern pointing at a single way
   function automatic logic [NWAYS-1:0] recent_for(input way_e w);
      return (w == WAY0) ? 2'b01 : 2'b10;
   endfunction

endpackage

// File: rtl/xlat_set.sv
module xlat_set
   import xlat_pkg::*;
#(
   parameter int unsigned TAG_W = 20,
   parameter int unsigned RPN_W = 20
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         touch_en,
   input  way_e                         touch_way,
   input  logic                         fill_en,
   input  logic [TAG_W-1:0]             fill_tag,
   input  logic [RPN_W-1:0]             fill_rpn,
   input  logic                         kill_en,
   input  logic [TAG_W-1:0]             kill_tag,
   output logic [NWAYS-1:0][TAG_W-1:0]  tag_o,
   output logic [NWAYS-1:0][RPN_W-1:0]  rpn_o,
   output logic [NWAYS-1:0]             live_o
);

   logic [NWAYS-1:0][TAG_W-1:0] tag_q, tag_d;
   logic [NWAYS-1:0][RPN_W-1:0] rpn_q, rpn_d;
   logic [NWAYS-1:0]            dead_q, dead_d;
   logic [NWAYS-1:0]            recent_q, recent_d;
   way_e                        victim;

   assign victim = pick_victim(recent_q);

   // order of effects: hit touch, then fill, then invalidate
   always_comb begin
      tag_d    = tag_q;
      rpn_d    = rpn_q;
      dead_d   = dead_q;
      recent_d = recent_q;
      if (touch_en) begin
         recent_d = recent_for(touch_way);
      end
      if (fill_en) begin
         tag_d[victim]  = fill_tag;
         rpn_d[victim]  = fill_rpn;
         dead_d[victim] = 1'b0;
         recent_d       = recent_for(victim);
      end
      if (kill_en) begin
         for (int w = 0; w < NWAYS; w++) begin
            if (tag_d[w] == kill_tag) begin
               dead_d[w] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q    <= '0;
         rpn_q    <= '0;
         dead_q   <= '1;
         recent_q <= '0;
      end else begin
         tag_q    <= tag_d;
         rpn_q    <= rpn_d;
         dead_q   <= dead_d;
         recent_q <= recent_d;
      end
   end

   assign tag_o  = tag_q;
   assign rpn_o  = rpn_q;
   assign live_o = ~dead_q;

endmodule

// File: rtl/xlat_bank.sv
module xlat_bank
   import xlat_pkg::*;
#(
   parameter int unsigned TAG_W   = 20,
   parameter int unsigned RPN_W   = 20,
   parameter int unsigned PG_BITS = 12,
   parameter int unsigned N_SETS  = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lk_act,
   input  logic                     lk_probe,
   input  logic [TAG_W-1:0]         lk_tag,
   input  logic [PG_BITS-1:0]       lk_off,
   output logic                     lk_hit,
   output logic [RPN_W+PG_BITS-1:0] lk_pa,
   input  logic                     fl_en,
   input  logic [TAG_W-1:0]         fl_tag,
   input  logic [RPN_W-1:0]         fl_rpn,
   input  logic                     inv_en,
   input  logic [TAG_W-1:0]         inv_tag
);

   localparam int unsigned IDX_W = $clog2(N_SETS);

   logic [NWAYS-1:0][TAG_W-1:0] st_tag  [N_SETS];
   logic [NWAYS-1:0][RPN_W-1:0] st_rpn  [N_SETS];
   logic [NWAYS-1:0]            st_live [N_SETS];

   logic [IDX_W-1:0]            lk_idx, fl_idx, inv_idx;
   logic [NWAYS-1:0][TAG_W-1:0] sel_tag;
   logic [NWAYS-1:0][RPN_W-1:0] sel_rpn;
   logic [NWAYS-1:0]            sel_live;
   logic [NWAYS-1:0]            match;
   way_e                        hit_way;
   logic                        touch;

   assign lk_idx  = lk_tag[IDX_W-1:0];
   assign fl_idx  = fl_tag[IDX_W-1:0];
   assign inv_idx = inv_tag[IDX_W-1:0];

   assign sel_tag  = st_tag[lk_idx];
   assign sel_rpn  = st_rpn[lk_idx];
   assign sel_live = st_live[lk_idx];

   for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
      assign match[w] = sel_live[w] && (sel_tag[w] == lk_tag);
   end

   assign hit_way = pick_hit(match);
   assign lk_hit  = |match;
   assign lk_pa   = lk_hit ? {sel_rpn[hit_way], lk_off} : '0;
   assign touch   = lk_act && !lk_probe && lk_hit;

   for (genvar s = 0; s < N_SETS; s++) begin : g_set
      xlat_set #(
         .TAG_W (TAG_W),
         .RPN_W (RPN_W)
      ) u_set (
         .clk       (clk),
         .rst_n     (rst_n),
         .touch_en  (touch && (lk_idx == IDX_W'(s))),
         .touch_way (hit_way),
         .fill_en   (fl_en && (fl_idx == IDX_W'(s))),
         .fill_tag  (fl_tag),
         .fill_rpn  (fl_rpn),
         .kill_en   (inv_en && (inv_idx == IDX_W'(s))),
         .kill_tag  (inv_tag),
         .tag_o     (st_tag[s]),
         .rpn_o     (st_rpn[s]),
         .live_o    (st_live[s])
      );
   end

endmodule

// File: rtl/xlat_pair_tlb.sv
module xlat_pair_tlb
   import xlat_pkg::*;
#(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PA_W    = 32,
   parameter int unsigned PG_BITS = 12,
   parameter int unsigned N_SETS  = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lk_req,
   input  logic [VA_W-1:0]         lk_va,
   input  logic                    lk_ifetch,
   input  logic                    lk_probe,
   output logic                    lk_hit,
   output logic [PA_W-1:0]         lk_pa,
   input  logic                    fl_en,
   input  logic [VA_W-1:0]         fl_va,
   input  logic [PA_W-PG_BITS-1:0] fl_rpn,
   input  logic                    fl_ifetch,
   input  logic                    inv_en,
   input  logic [VA_W-1:0]         inv_va
);

   localparam int unsigned TAG_W  = VA_W - PG_BITS;
   localparam int unsigned RPN_W  = PA_W - PG_BITS;
   localparam int unsigned IDX_W  = $clog2(N_SETS);
   localparam int unsigned N_BUFS = 2;

   if (N_SETS < 2 || (1 << IDX_W) != N_SETS) begin : g_bad_sets
      $error("xlat_pair_tlb: N_SETS must be a power of two, at least 2");
   end
   if (PG_BITS + IDX_W > VA_W) begin : g_bad_index
      $error("xlat_pair_tlb: set index does not fit above the page offset");
   end
   if (PG_BITS >= PA_W) begin : g_bad_pa
      $error("xlat_pair_tlb: physical address narrower than page offset");
   end

   logic            bank_hit [N_BUFS];
   logic [PA_W-1:0] bank_pa  [N_BUFS];

   // bank 0 serves data accesses, bank 1 instruction fetches
   for (genvar b = 0; b < N_BUFS; b++) begin : g_bank
      localparam logic SEL = (b == 1);
      xlat_bank #(
         .TAG_W   (TAG_W),
         .RPN_W   (RPN_W),
         .PG_BITS (PG_BITS),
         .N_SETS  (N_SETS)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_act   (lk_req && (lk_ifetch == SEL)),
         .lk_probe (lk_probe),
         .lk_tag   (lk_va[VA_W-1:PG_BITS]),
         .lk_off   (lk_va[PG_BITS-1:0]),
         .lk_hit   (bank_hit[b]),
         .lk_pa    (bank_pa[b]),
         .fl_en    (fl_en && (fl_ifetch == SEL)),
         .fl_tag   (fl_va[VA_W-1:PG_BITS]),
         .fl_rpn   (fl_rpn),
         .inv_en   (inv_en),
         .inv_tag  (inv_va[VA_W-1:PG_BITS])
      );
   end

   assign lk_hit = lk_ifetch ? bank_hit[1] : bank_hit[0];
   assign lk_pa  = lk_ifetch ? bank_pa[1]  : bank_pa[0];

endmodule

// File: rtl/xlat_pair_tlb_chk.sv
module xlat_pair_tlb_chk #(
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PA_W    = 32,
   parameter int unsigned PG_BITS = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    lk_req,
   input logic [VA_W-1:0]         lk_va,
   input logic                    lk_ifetch,
   input logic                    lk_probe,
   input logic                    lk_hit,
   input logic [PA_W-1:0]         lk_pa,
   input logic                    fl_en,
   input logic [VA_W-PG_BITS-1:0] fl_pg,
   input logic                    fl_ifetch,
   input logic                    inv_en,
   input logic [VA_W-PG_BITS-1:0] inv_pg
);

   // R1: first cycle out of reset never hits
   a_r1_reset_miss: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !lk_hit);

   // R2: miss returns zero address
   a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_pa == '0));

   // R2: a missing real lookup with no fill or invalidate leaves the same lookup missing
   a_r2_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && !lk_hit && !fl_en && !inv_en) ##1
      ($stable(lk_va) && $stable(lk_ifetch)) |-> !lk_hit);

   // R4: offset passes through on a hit
   a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_pa[PG_BITS-1:0] == lk_va[PG_BITS-1:0]));

   // R3: a filled page hits one cycle later unless invalidated with it
   a_r3_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && !inv_en) ##1
      ((lk_va[VA_W-1:PG_BITS] == $past(fl_pg)) && (lk_ifetch == $past(fl_ifetch)))
      |-> lk_hit);

   // R8: an invalidated page misses in either buffer one cycle later
   a_r8_inv_both: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en ##1 (lk_va[VA_W-1:PG_BITS] == $past(inv_pg)) |-> !lk_hit);

   // R7: a probe with no fill or invalidate changes nothing observable
   a_r7_probe_still: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && lk_probe && !fl_en && !inv_en) ##1
      ($stable(lk_va) && $stable(lk_ifetch)) |-> ($stable(lk_hit) && $stable(lk_pa)));

endmodule

bind xlat_pair_tlb xlat_pair_tlb_chk #(
   .VA_W    (VA_W),
   .PA_W    (PA_W),
   .PG_BITS (PG_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_req    (lk_req),
   .lk_va     (lk_va),
   .lk_ifetch (lk_ifetch),
   .lk_probe  (lk_probe),
   .lk_hit    (lk_hit),
   .lk_pa     (lk_pa),
   .fl_en     (fl_en),
   .fl_pg     (fl_va[VA_W-1:PG_BITS]),
   .fl_ifetch (fl_ifetch),
   .inv_en    (inv_en),
   .inv_pg    (inv_va[VA_W-1:PG_BITS])
);

// File: tb/test_xlat_pair_tlb.sv
`timescale 1ns/1ps
module test_xlat_pair_tlb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = '0;
   logic        lk_ifetch = 1'b0;
   logic        lk_probe = 1'b0;
   logic        lk_hit;
   logic [31:0] lk_pa;
   logic        fl_en = 1'b0;
   logic [31:0] fl_va = '0;
   logic [19:0] fl_rpn = '0;
   logic        fl_ifetch = 1'b0;
   logic        inv_en = 1'b0;
   logic [31:0] inv_va = '0;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic        hit;
      logic [31:0] pa;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #5 clk = ~clk;

   xlat_pair_tlb i_xlat_pair_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_req(lk_req), .lk_va(lk_va), .lk_ifetch(lk_ifetch), .lk_probe(lk_probe),
      .lk_hit(lk_hit), .lk_pa(lk_pa),
      .fl_en(fl_en), .fl_va(fl_va), .fl_rpn(fl_rpn), .fl_ifetch(fl_ifetch),
      .inv_en(inv_en), .inv_va(inv_va)
   );

   task automatic quiet();
      lk_req = 1'b0; lk_probe = 1'b0; fl_en = 1'b0; inv_en = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
      quiet();
   endtask

   task automatic look(input logic [31:0] va, input logic ins, input logic prb,
                       input logic ehit, input logic [31:0] epa, input string rq);
      exp_t e;
      @(negedge clk);
      quiet();
      lk_req = 1'b1; lk_va = va; lk_ifetch = ins; lk_probe = prb;
      e.hit = ehit; e.pa = epa; e.req = rq;
      sb.push_back(e);
   endtask

   task automatic fill(input logic [31:0] va, input logic [19:0] rpn, input logic ins);
      @(negedge clk);
      quiet();
      fl_en = 1'b1; fl_va = va; fl_rpn = rpn; fl_ifetch = ins;
   endtask

   task automatic inval(input logic [31:0] va);
      @(negedge clk);
      quiet();
      inv_en = 1'b1; inv_va = va;
   endtask

   task automatic fill_inval(input logic [31:0] va, input logic [19:0] rpn,
                             input logic [31:0] iva);
      @(negedge clk);
      quiet();
      fl_en = 1'b1; fl_va = va; fl_rpn = rpn; fl_ifetch = 1'b0;
      inv_en = 1'b1; inv_va = iva;
   endtask

   // monitor: compares the combinational lookup result mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (lk_hit !== e.hit || lk_pa !== e.pa) begin
               errors++;
               $display("FAIL %s: actual hit=%0b pa=%08h expected hit=%0b pa=%08h",
                        e.req, lk_hit, lk_pa, e.hit, e.pa);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset
      look(32'h0000_1234, 1'b0, 1'b0, 1'b0, 32'h0, "R1 data");
      look(32'h0000_5678, 1'b1, 1'b0, 1'b0, 32'h0, "R1 insn");

      // R3 / R4: fill and translate (set 5)
      fill(32'h0000_5000, 20'h00ABC, 1'b0);
      look(32'h0000_5678, 1'b0, 1'b0, 1'b1, 32'h00AB_C678, "R3 fill visible");
      look(32'h0000_5678, 1'b1, 1'b0, 1'b0, 32'h0, "R5 other buffer");
      look(32'h0000_6678, 1'b0, 1'b0, 1'b0, 32'h0, "R2 other set");

      // R6: replacement order in set 5
      fill(32'h0004_5000, 20'h11111, 1'b0);
      look(32'h0004_5010, 1'b0, 1'b0, 1'b1, 32'h1111_1010, "R3 second way");
      look(32'h0000_5004, 1'b0, 1'b0, 1'b1, 32'h00AB_C004, "R6 touch way0");
      fill(32'h0008_5000, 20'h22222, 1'b0);
      look(32'h0004_5010, 1'b0, 1'b0, 1'b0, 32'h0, "R6 way1 replaced");
      look(32'h0000_5001, 1'b0, 1'b0, 1'b1, 32'h00AB_C001, "R6 way0 kept");
      look(32'h0008_5ffc, 1'b0, 1'b0, 1'b1, 32'h2222_2ffc, "R6 new entry");

      // R7: probe does not move the recent flag
      look(32'h0000_5abc, 1'b0, 1'b1, 1'b1, 32'h00AB_Cabc, "R7 probe hit");
      fill(32'h000C_5000, 20'h33333, 1'b0);
      look(32'h0000_5abc, 1'b0, 1'b0, 1'b0, 32'h0, "R7 probed way replaced");
      look(32'h0008_5004, 1'b0, 1'b0, 1'b1, 32'h2222_2004, "R7 recent way kept");
      look(32'h000C_5100, 1'b0, 1'b0, 1'b1, 32'h3333_3100, "R7 new entry");

      // R5 / R8: same page in both buffers, one invalidation
      fill(32'h000C_5000, 20'h44444, 1'b1);
      look(32'h000C_5200, 1'b1, 1'b0, 1'b1, 32'h4444_4200, "R5 insn entry");
      inval(32'h000C_5abc);
      look(32'h000C_5100, 1'b0, 1'b0, 1'b0, 32'h0, "R8 data cleared");
      look(32'h000C_5200, 1'b1, 1'b0, 1'b0, 32'h0, "R8 insn cleared");
      look(32'h0008_5004, 1'b0, 1'b0, 1'b1, 32'h2222_2004, "R8 neighbour kept");

      // R9: fill and invalidate together
      fill_inval(32'h0010_0000, 20'h55555, 32'h0010_0fff);
      look(32'h0010_0010, 1'b0, 1'b0, 1'b0, 32'h0, "R9 fill then invalidate");
      fill(32'h0010_0000, 20'h55555, 1'b0);
      look(32'h0010_0010, 1'b0, 1'b0, 1'b1, 32'h5555_5010, "R9 refill");

      // R10: duplicate tag, way 0 wins
      fill(32'h0020_1000, 20'h66666, 1'b0);
      fill(32'h0020_1000, 20'h77777, 1'b0);
      look(32'h0020_1234, 1'b0, 1'b0, 1'b1, 32'h6666_6234, "R10 way0 priority");
      inval(32'h0020_1000);
      look(32'h0020_1234, 1'b0, 1'b0, 1'b0, 32'h0, "R8 both duplicates cleared");

      // R4: top set and all-ones address
      fill(32'h0003_F000, 20'h0FFFF, 1'b0);
      look(32'h0003_FFFF, 1'b0, 1'b0, 1'b1, 32'h0FFF_FFFF, "R4 set 63");
      fill(32'hFFFF_F000, 20'hFFFFF, 1'b1);
      look(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, "R4 full tag");
      look(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h0, "R5 data side empty");

      idle();
      idle();
      idle();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule